// File: doc/BRIEF.md
# Multiway Branch Exit Table

This block resolves a multiway branch in a single step. It keeps a small bank of one-bit condition flags and a short ordered list of pending branch entries. Compare logic elsewhere writes individual flags. Each prepare request adds one entry to the list. An entry combines two flags with a relation (OR, AND or equality) and carries a target address. When an exit request arrives, the block evaluates every held entry against the flags as they stand in that cycle. It reports the target of the oldest entry whose relation holds, or a fall-through if none holds. The list is then emptied.

To test a single flag, name the same flag twice with AND. To send several alternatives to one target, prepare several entries that carry the same address. If a prepare arrives while the list is full, it is discarded and a sticky overflow flag is raised. The next exit clears that flag.

Top module: `mwb_exit_unit`

## Requirements
- R1: After reset all condition flags are 0, the entry list is empty, `ovf_flag` is 0 and `res_valid`, `res_taken`, `res_target` are 0.
- R2: A compare write sets flag `cmp_sel` to `cmp_bit`. The write is seen by an exit issued in any later cycle, but not by an exit issued in the same cycle. Flags are read at exit time, not when an entry is prepared.
- R3: A prepare issued while DEPTH entries are held and no exit is requested is discarded and sets `ovf_flag`. The flag stays at 1 until an exit request clears it.
- R4: The `prep_op` encoding is 0 = OR, 1 = AND, 2 = equality (both flags equal), 3 = never true.
- R5: On exit, the selected target is the one of the earliest-prepared entry whose relation is true. Later true entries are ignored.
- R6: If no held entry is true, the exit reports `res_taken` = 0 and `res_target` = 0. Whenever `res_valid` is 0, `res_taken` and `res_target` are 0.
- R7: An exit empties the entry list. A later exit with no prepares in between reports not-taken.
- R8: `res_valid` is 1 in exactly the cycle after each cycle with `exit_req` = 1, and is 0 otherwise.
- R9: A prepare issued in the same cycle as an exit is not evaluated by that exit. It becomes the first entry of the new list.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_we | input | 1 | Compare result write enable |
| cmp_sel | input | 3 | Index of the flag to write |
| cmp_bit | input | 1 | Value written to the flag |
| prep_valid | input | 1 | Append an entry |
| prep_op | input | 2 | Relation code (see R4) |
| prep_src_a | input | 3 | First flag index of the entry |
| prep_src_b | input | 3 | Second flag index of the entry |
| prep_target | input | 16 | Branch target of the entry |
| exit_req | input | 1 | Resolve the list and empty it |
| res_valid | output | 1 | Exit result strobe |
| res_taken | output | 1 | A held entry was true |
| res_target | output | 16 | Selected target, 0 if not taken |
| ovf_flag | output | 1 | Sticky dropped-prepare flag |

## Verification
Directed cases try each relation code on known flag values. They also build lists in which several entries are true, so that first-true selection can be told apart from last-true or any-true selection. Overflow cases fill the list so that only the dropped fifth entry would be true, which shows whether the drop really happens. A flag write in the same cycle as an exit, and exits that collide with a prepare, separate the ordering at exit time from the ordering at prepare time. Long random mixes of writes, prepares and exits are compared each cycle against a reference model kept in the bench.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

   typedef enum logic [1:0] {
      PRED_OR   = 2'd0,
      PRED_AND  = 2'd1,
      PRED_EQ   = 2'd2,
      PRED_NONE = 2'd3
   } pred_op_e;

   function automatic logic pred_eval(input logic [1:0] op, input logic x, input logic y);
      logic r;
      unique case (op)
         PRED_OR:  r = x | y;
         PRED_AND: r = x & y;
         PRED_EQ:  r = ~(x ^ y);
         default:  r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/mwb_cond_bank.sv
module mwb_cond_bank #(
   parameter int NCOND = 8,
   localparam int IDX_W = (NCOND > 1) ? $clog2(NCOND) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic             val,
   output logic [NCOND-1:0] flags
);

   logic [NCOND-1:0] flags_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else begin
         for (int i = 0; i < NCOND; i++) begin
            if (we && (idx == IDX_W'(i)))
               flags_q[i] <= val;
         end
      end
   end

   assign flags = flags_q;

endmodule

// File: rtl/mwb_entry_table.sv
module mwb_entry_table #(
   parameter int DEPTH  = 4,
   parameter int IDX_W  = 3,
   parameter int ADDR_W = 16,
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push,
   input  logic [1:0]                    push_op,
   input  logic [IDX_W-1:0]              push_a,
   input  logic [IDX_W-1:0]              push_b,
   input  logic [ADDR_W-1:0]             push_tgt,
   input  logic                          flush,
   output logic [DEPTH-1:0][1:0]         ent_op,
   output logic [DEPTH-1:0][IDX_W-1:0]   ent_a,
   output logic [DEPTH-1:0][IDX_W-1:0]   ent_b,
   output logic [DEPTH-1:0][ADDR_W-1:0]  ent_tgt,
   output logic [DEPTH-1:0]              ent_vld,
   output logic [CNT_W-1:0]              occ,
   output logic                          full,
   output logic                          drop
);

   logic [CNT_W-1:0]  occ_q;
   logic              wr_en;
   logic [SLOT_W-1:0] wr_slot;

   assign full    = (occ_q == CNT_W'(DEPTH));
   assign wr_en   = push && (flush || !full);
   assign drop    = push && full && !flush;
   assign wr_slot = flush ? '0 : occ_q[SLOT_W-1:0];
   assign occ     = occ_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         occ_q <= '0;
      else if (flush)
         occ_q <= push ? CNT_W'(1) : '0;
      else if (wr_en)
         occ_q <= occ_q + CNT_W'(1);
   end

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_op[s]  <= '0;
            ent_a[s]   <= '0;
            ent_b[s]   <= '0;
            ent_tgt[s] <= '0;
         end else if (wr_en && (wr_slot == SLOT_W'(s))) begin
            ent_op[s]  <= push_op;
            ent_a[s]   <= push_a;
            ent_b[s]   <= push_b;
            ent_tgt[s] <= push_tgt;
         end
      end
      assign ent_vld[s] = (occ_q > CNT_W'(s));
   end

endmodule

// File: rtl/mwb_pick.sv
module mwb_pick #(
   parameter int DEPTH       = 4,
   parameter int ADDR_W      = 16,
   parameter bit ONEHOT_PICK = 1'b0
) (
   input  logic [DEPTH-1:0]             hit,
   input  logic [DEPTH-1:0][ADDR_W-1:0] tgt,
   output logic                         any,
   output logic [ADDR_W-1:0]            sel_tgt
);

   assign any = |hit;

   if (ONEHOT_PICK) begin : g_onehot
      logic [DEPTH-1:0] first;
      assign first = hit & ~(hit - DEPTH'(1));
      always_comb begin
         sel_tgt = '0;
         for (int i = 0; i < DEPTH; i++)
            sel_tgt |= first[i] ? tgt[i] : '0;
      end
   end else begin : g_scan
      always_comb begin
         sel_tgt = '0;
         for (int i = DEPTH - 1; i >= 0; i--)
            if (hit[i]) sel_tgt = tgt[i];
      end
   end

endmodule

// File: rtl/mwb_exit_unit.sv
module mwb_exit_unit #(
   parameter int NCOND       = 8,
   parameter int DEPTH       = 4,
   parameter int ADDR_W      = 16,
   parameter bit ONEHOT_PICK = 1'b0,
   localparam int IDX_W = (NCOND > 1) ? $clog2(NCOND) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_we,
   input  logic [IDX_W-1:0]  cmp_sel,
   input  logic              cmp_bit,
   input  logic              prep_valid,
   input  logic [1:0]        prep_op,
   input  logic [IDX_W-1:0]  prep_src_a,
   input  logic [IDX_W-1:0]  prep_src_b,
   input  logic [ADDR_W-1:0] prep_target,
   input  logic              exit_req,
   output logic              res_valid,
   output logic              res_taken,
   output logic [ADDR_W-1:0] res_target,
   output logic              ovf_flag
);
   import mwb_pkg::*;

   if (NCOND < 2)   begin : g_bad_ncond $error("NCOND must be at least 2"); end
   if (DEPTH < 1)   begin : g_bad_depth $error("DEPTH must be at least 1"); end
   if (DEPTH > 64)  begin : g_big_depth $error("DEPTH above 64 is not supported"); end
   if (ADDR_W < 1)  begin : g_bad_addr  $error("ADDR_W must be positive"); end

   logic [NCOND-1:0]             flags;
   logic [DEPTH-1:0][1:0]        ent_op;
   logic [DEPTH-1:0][IDX_W-1:0]  ent_a;
   logic [DEPTH-1:0][IDX_W-1:0]  ent_b;
   logic [DEPTH-1:0][ADDR_W-1:0] ent_tgt;
   logic [DEPTH-1:0]             ent_vld;
   logic [CNT_W-1:0]             occ;
   logic                         tbl_full;
   logic                         tbl_drop;
   logic [DEPTH-1:0]             hit;
   logic                         any_hit;
   logic [ADDR_W-1:0]            pick_tgt;

   mwb_cond_bank #(.NCOND(NCOND)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cmp_we),
      .idx   (cmp_sel),
      .val   (cmp_bit),
      .flags (flags)
   );

   mwb_entry_table #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (prep_valid),
      .push_op  (prep_op),
      .push_a   (prep_src_a),
      .push_b   (prep_src_b),
      .push_tgt (prep_target),
      .flush    (exit_req),
      .ent_op   (ent_op),
      .ent_a    (ent_a),
      .ent_b    (ent_b),
      .ent_tgt  (ent_tgt),
      .ent_vld  (ent_vld),
      .occ      (occ),
      .full     (tbl_full),
      .drop     (tbl_drop)
   );

   for (genvar e = 0; e < DEPTH; e++) begin : g_eval
      logic fa, fb;
      assign fa     = (int'(ent_a[e]) < NCOND) ? flags[ent_a[e]] : 1'b0;
      assign fb     = (int'(ent_b[e]) < NCOND) ? flags[ent_b[e]] : 1'b0;
      assign hit[e] = ent_vld[e] && pred_eval(ent_op[e], fa, fb);
   end

   mwb_pick #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .ONEHOT_PICK(ONEHOT_PICK)) u_pick (
      .hit     (hit),
      .tgt     (ent_tgt),
      .any     (any_hit),
      .sel_tgt (pick_tgt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_taken  <= 1'b0;
         res_target <= '0;
         ovf_flag   <= 1'b0;
      end else begin
         res_valid  <= exit_req;
         res_taken  <= exit_req && any_hit;
         res_target <= (exit_req && any_hit) ? pick_tgt : '0;
         if (exit_req)
            ovf_flag <= 1'b0;
         else if (tbl_drop)
            ovf_flag <= 1'b1;
      end
   end

endmodule

// File: rtl/mwb_exit_unit_chk.sv
module mwb_exit_unit_chk #(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exit_req,
   input logic              prep_valid,
   input logic              full,
   input logic [CNT_W-1:0]  occ,
   input logic              res_valid,
   input logic              res_taken,
   input logic [ADDR_W-1:0] res_target,
   input logic              ovf_flag
);

   assert_result_follows_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exit_req |=> res_valid);

   assert_result_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !exit_req |=> !res_valid);

   assert_idle_outputs_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_taken && res_target == '0));

   assert_fallthrough_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_taken) |-> (res_target == '0));

   assert_overflow_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (prep_valid && full && !exit_req) |=> ovf_flag);

   assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !exit_req) |=> ovf_flag);

   assert_occupancy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH));

   assert_exit_flushes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exit_req |=> (!ovf_flag && occ <= CNT_W'(1)));

endmodule

bind mwb_exit_unit mwb_exit_unit_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .exit_req   (exit_req),
   .prep_valid (prep_valid),
   .full       (tbl_full),
   .occ        (occ),
   .res_valid  (res_valid),
   .res_taken  (res_taken),
   .res_target (res_target),
   .ovf_flag   (ovf_flag)
);

// File: tb/mwb_exit_unit_test.sv
module mwb_exit_unit_test;
   localparam int NC = 8;
   localparam int D  = 4;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmp_we = 1'b0;
   logic [2:0]    cmp_sel = '0;
   logic          cmp_bit = 1'b0;
   logic          prep_valid = 1'b0;
   logic [1:0]    prep_op = '0;
   logic [2:0]    prep_src_a = '0;
   logic [2:0]    prep_src_b = '0;
   logic [AW-1:0] prep_target = '0;
   logic          exit_req = 1'b0;
   logic          res_valid, res_taken, ovf_flag;
   logic [AW-1:0] res_target;

   always #2 clk = ~clk;

   mwb_exit_unit #(.NCOND(NC), .DEPTH(D), .ADDR_W(AW)) uut (.*);

   int    n_checks = 0;
   int    n_fail   = 0;
   string tag      = "";
   bit    done     = 1'b0;

   // reference model
   bit          m_cond [NC];
   int          m_cnt;
   int          m_op [D];
   int          m_a [D];
   int          m_b [D];
   int          m_tgt [D];
   bit          m_ovf;
   bit          e_valid, e_taken;
   int          e_target;

   function automatic bit rel(int op, bit x, bit y);
      if (op == 0) return x || y;
      if (op == 1) return x && y;
      if (op == 2) return x == y;
      return 1'b0;
   endfunction

   task automatic chk(string t, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
      end
   endtask

   task automatic cyc(bit ex, bit pv, int op, int a, int b, int tg, bit cw, int ci, bit cv);
      @(negedge clk);
      chk((tag != "") ? tag : "R8", int'(res_valid), int'(e_valid));
      chk((tag != "") ? tag : (e_taken ? "R5" : "R6"), int'(res_taken), int'(e_taken));
      chk((tag != "") ? tag : "R5", int'(res_target), e_target);
      chk((tag != "") ? tag : "R3", int'(ovf_flag), int'(m_ovf));
      exit_req = ex; prep_valid = pv; prep_op = 2'(op);
      prep_src_a = 3'(a); prep_src_b = 3'(b); prep_target = AW'(tg);
      cmp_we = cw; cmp_sel = 3'(ci); cmp_bit = cv;
      // expected outputs after the coming edge
      e_valid = ex; e_taken = 1'b0; e_target = 0;
      if (ex) begin
         for (int i = m_cnt - 1; i >= 0; i--)
            if (rel(m_op[i], m_cond[m_a[i]], m_cond[m_b[i]])) begin
               e_taken = 1'b1; e_target = m_tgt[i];
            end
         m_ovf = 1'b0;
         m_cnt = 0;
      end
      if (pv) begin
         if (m_cnt < D) begin
            m_op[m_cnt] = op; m_a[m_cnt] = a; m_b[m_cnt] = b; m_tgt[m_cnt] = tg;
            m_cnt++;
         end else begin
            m_ovf = 1'b1;
         end
      end
      if (cw) m_cond[ci] = cv;
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic prep(int op, int a, int b, int tg);
      cyc(0, 1, op, a, b, tg, 0, 0, 0);
   endtask
   task automatic wr(int ci, bit cv);
      cyc(0, 0, 0, 0, 0, 0, 1, ci, cv);
   endtask
   task automatic ex();
      cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < NC; i++) m_cond[i] = 1'b0;
      m_cnt = 0; m_ovf = 1'b0; e_valid = 0; e_taken = 0; e_target = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      tag = "R1";
      idle();
      prep(1, 6, 6, 5); ex(); idle();

      tag = "R4";
      wr(0, 1); wr(1, 0);
      prep(0, 0, 1, 10); ex();
      prep(1, 0, 1, 11); ex();
      prep(2, 1, 2, 12); ex();
      prep(3, 0, 0, 13); ex();
      prep(2, 0, 1, 14); ex(); idle();

      tag = "R5";
      prep(1, 1, 1, 20); prep(0, 0, 0, 21); prep(2, 0, 0, 22); ex();
      prep(1, 1, 1, 23); prep(1, 1, 1, 24); prep(1, 1, 1, 25); prep(1, 0, 0, 26); ex(); idle();

      tag = "R3";
      prep(1, 1, 1, 30); prep(1, 1, 1, 31); prep(1, 1, 1, 32); prep(1, 1, 1, 33);
      prep(0, 0, 0, 34); idle(); idle(); ex(); idle();

      tag = "R2";
      prep(1, 3, 3, 40); cyc(1, 0, 0, 0, 0, 0, 1, 3, 1);
      prep(1, 3, 3, 41); ex();
      prep(1, 4, 4, 42); wr(4, 1); ex(); idle();

      tag = "R7";
      ex(); ex(); idle();

      tag = "R9";
      prep(1, 1, 1, 50); cyc(1, 1, 0, 0, 0, 51, 0, 0, 0); ex(); idle();

      tag = "R8";
      prep(0, 0, 0, 60); ex(); ex(); idle(); idle();

      tag = "";
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = $urandom_range(0, 99);
         cyc(r < 15, $urandom_range(0, 99) < 45, $urandom_range(0, 3),
             $urandom_range(0, NC - 1), $urandom_range(0, NC - 1),
             $urandom_range(0, 65535), $urandom_range(0, 99) < 40,
             $urandom_range(0, NC - 1), $urandom_range(0, 1));
      end
      idle(); idle();

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule